// File: doc/BRIEF.md
# Tuner Control Bus Slave

This block is a write-only two-wire serial bus slave that sits in front of a frequency-synthesis tuner. It watches oversampled copies of the clock and data lines, recognises start and stop conditions, checks the address byte against a fixed prefix and a two-bit hardware address select, and acknowledges each accepted byte by pulling the data line low. Data bytes arrive in pairs, and the top bit of the first byte in each pair says what the pair holds. A 0 means a 15-bit divider ratio. A 1 means a control word that carries the pump-current, charge-pump tristate, test and amplifier-disable bits together with five port outputs.

There is no register pointer. Divider and control pairs may come in either order, and a telegram may stop after the first byte of any pair. Each byte is written into its fields at its acknowledge. A truncated telegram therefore keeps the fields it has already delivered. The pull-down is released during reset, so the block never holds the bus low after power-up.

Top module: `tuner_bus_slave`

## Requirements
- R1: While reset is asserted and right after it, `sda_pull_o` is 0 and every register output is 0.
- R2: An address byte equal to 1,1,0,0,0,`addr_sel_i[1]`,`addr_sel_i[0]`,0 (MSB first) is acknowledged: `sda_pull_o` is 1 from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock.
- R3: An address byte with any other value, including a read bit of 1, gets no acknowledge. Neither it nor any later byte up to the next start is acknowledged, and no register field changes.
- R4: A pair whose first byte has bit 7 = 0 is divider data: bits 6..0 of that byte become `div_ratio_o[14:8]` and the next byte becomes `div_ratio_o[7:0]`.
- R5: A pair whose first byte has bit 7 = 1 is control data: bit 6 → `pump_hi_o`, bit 5 → `test_sel_o`, bit 4 → `cp_tristate_o`, bit 0 → `ud_off_o`. In the next byte, bit 7 → `port_o[4]`, bit 4 → `port_o[3]`, bit 2 → `port_o[2]`, bit 1 → `port_o[1]` and bit 0 → `port_o[0]`. A port bit of 1 turns that output on.
- R6: After a matching address, every data byte is acknowledged in the same way as the address byte.
- R7: Divider and control pairs are accepted in either order within one telegram.
- R8: A stop after the first byte of a pair keeps the fields that byte wrote. The fields of the missing second byte keep their old values.
- R9: A repeated start makes the next byte an address byte and makes the byte after it the first byte of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 2 | Hardware address select (address bits 2..1) |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| div_ratio_o | output | 15 | Divider ratio |
| pump_hi_o | output | 1 | High charge-pump current |
| cp_tristate_o | output | 1 | Charge-pump output in high impedance |
| test_sel_o | output | 1 | Test signal routed to a port |
| ud_off_o | output | 1 | Tuning amplifier output disabled |
| port_o | output | 5 | Port outputs {P7, P4, P2, P1, P0} |

## Verification
The bench goes after the pair classification. A decoder that fixed the kind by byte position instead of by the leading bit would put control data into the divider when the control pair comes first. It also tests telegrams cut off after one byte of a pair. A design that latched only at the end of a pair would lose the upper divider bits or the control bits there. An address with the wrong select bits or a read bit must be met with silence and no field changes, and an acknowledge there shows up at once as a pulled line. Repeated starts in the middle of a pair catch a design that carries the pair position across the restart and reads the next byte as a second byte.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_SKIP
   } bus_state_t;

   localparam logic [4:0] ADDR_PREFIX = 5'b11000;
   localparam int         BYTE_W      = 8;
endpackage

// File: rtl/tuner_line_sync.sv
module tuner_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tuner_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_ff[STAGES-1];
         sda_d  <= sda_ff[STAGES-1];
      end
   end

   assign scl_lvl   = scl_ff[STAGES-1];
   assign sda_lvl   = sda_ff[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/tuner_byte_fsm.sv
module tuner_byte_fsm
   import tuner_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [1:0]        addr_sel,
   output logic              ack_q,
   output logic              byte_wr,
   output logic              wr_second,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   bus_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         ack_q     <= 1'b0;
         second_q  <= 1'b0;
         byte_wr   <= 1'b0;
         wr_second <= 1'b0;
      end else begin
         byte_wr <= 1'b0;
         if (start_evt) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            ack_q    <= 1'b0;
            second_q <= 1'b0;
         end else if (stop_evt) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ack_q <= 1'b0;
         end else if (state == ST_ADDR || state == ST_DATA) begin
            if (scl_rise && cnt < FULL) begin
               shreg <= {shreg[BYTE_W-2:0], sda_lvl};
               cnt   <= cnt + 1'b1;
            end else if (scl_fall) begin
               if (ack_q) begin
                  ack_q <= 1'b0;
                  cnt   <= '0;
               end else if (cnt == FULL) begin
                  if (state == ST_ADDR) begin
                     if (shreg == {ADDR_PREFIX, addr_sel, 1'b0}) begin
                        ack_q <= 1'b1;
                        state <= ST_DATA;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end else begin
                     ack_q     <= 1'b1;
                     byte_wr   <= 1'b1;
                     wr_second <= second_q;
                     second_q  <= ~second_q;
                  end
               end
            end
         end
      end
   end

   assign byte_val = shreg;

   // R1
   rst_release_chk: assert property (@(posedge clk) !rst_n |=> !ack_q);
   // R2
   ack_on_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> !scl_lvl);
   // R3
   skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !ack_q);
   // R9
   restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (state == ST_ADDR && !second_q));
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
   import tuner_pkg::*;
#(
   parameter int DIV_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_wr,
   input  logic              wr_second,
   input  logic [BYTE_W-1:0] byte_val,
   output logic [DIV_W-1:0]  div_ratio,
   output logic              pump_hi,
   output logic              test_sel,
   output logic              cp_tri,
   output logic              ud_off,
   output logic [4:0]        ports
);
   localparam int HI_W = DIV_W - BYTE_W;

   if (DIV_W < BYTE_W + 1 || DIV_W > 2*BYTE_W - 1) begin : g_bad_div
      $error("tuner_reg_bank: DIV_W must lie in 9..15");
   end

   logic kind_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_ratio <= '0;
         pump_hi   <= 1'b0;
         test_sel  <= 1'b0;
         cp_tri    <= 1'b0;
         ud_off    <= 1'b0;
         ports     <= '0;
         kind_ctl  <= 1'b0;
      end else if (byte_wr) begin
         if (!wr_second) begin
            kind_ctl <= byte_val[7];
            if (!byte_val[7]) begin
               div_ratio[DIV_W-1:BYTE_W] <= byte_val[HI_W-1:0];
            end else begin
               pump_hi  <= byte_val[6];
               test_sel <= byte_val[5];
               cp_tri   <= byte_val[4];
               ud_off   <= byte_val[0];
            end
         end else if (!kind_ctl) begin
            div_ratio[BYTE_W-1:0] <= byte_val;
         end else begin
            ports <= {byte_val[7], byte_val[4], byte_val[2:0]};
         end
      end
   end

   // R8
   div_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_ratio) |-> $past(byte_wr));
   // R5
   ports_on_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ports) |-> $past(byte_wr && wr_second));
endmodule

// File: rtl/tuner_bus_slave.sv
module tuner_bus_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_W       = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [1:0]       addr_sel_i,
   output logic             sda_pull_o,
   output logic [DIV_W-1:0] div_ratio_o,
   output logic             pump_hi_o,
   output logic             cp_tristate_o,
   output logic             test_sel_o,
   output logic             ud_off_o,
   output logic [4:0]       port_o
);
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   logic byte_wr, wr_second;
   logic [7:0] byte_val;

   tuner_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
   );

   tuner_byte_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
      .stop_evt(stop_evt), .addr_sel(addr_sel_i), .ack_q(sda_pull_o),
      .byte_wr(byte_wr), .wr_second(wr_second), .byte_val(byte_val)
   );

   tuner_reg_bank #(.DIV_W(DIV_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .wr_second(wr_second),
      .byte_val(byte_val), .div_ratio(div_ratio_o), .pump_hi(pump_hi_o),
      .test_sel(test_sel_o), .cp_tri(cp_tristate_o), .ud_off(ud_off_o),
      .ports(port_o)
   );
endmodule

// File: tb/tuner_bus_slave_tb_top.sv
module tuner_bus_slave_tb_top;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_drv = 1'b1;
   logic [1:0] asel = 2'b10;
   logic sda_pull;
   logic [14:0] div_o;
   logic pump_o, tri_o, test_o, ud_o;
   logic [4:0] port_o;
   wire sda_line = sda_drv & ~sda_pull;

   int n_chk = 0;
   int n_fail = 0;

   logic [14:0] e_div = '0;
   logic e_pump = 0, e_tri = 0, e_test = 0, e_ud = 0;
   logic [4:0] e_port = '0;
   logic m_second = 0, m_kind = 0;

   always #2 clk = ~clk;

   tuner_bus_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .addr_sel_i(asel), .sda_pull_o(sda_pull), .div_ratio_o(div_o),
      .pump_hi_o(pump_o), .cp_tristate_o(tri_o), .test_sel_o(test_o),
      .ud_off_o(ud_o), .port_o(port_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_h;
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_drv = 1; wait_h; scl = 1; wait_h; sda_drv = 0; wait_h; scl = 0; wait_h;
   endtask

   task automatic bus_stop;
      sda_drv = 0; wait_h; scl = 1; wait_h; sda_drv = 1; wait_h; wait_h;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_drv = b[i]; wait_h; scl = 1; wait_h; scl = 0; wait_h;
      end
      sda_drv = 1; wait_h; ack = sda_pull; scl = 1; wait_h; scl = 0; wait_h;
   endtask

   function automatic logic [7:0] addr_of(input logic [1:0] s);
      return {5'b11000, s, 1'b0};
   endfunction

   task automatic model_byte(input logic [7:0] b);
      if (!m_second) begin
         m_kind = b[7];
         if (!b[7]) e_div[14:8] = b[6:0];
         else begin e_pump = b[6]; e_test = b[5]; e_tri = b[4]; e_ud = b[0]; end
      end else if (!m_kind) e_div[7:0] = b;
      else e_port = {b[7], b[4], b[2], b[1], b[0]};
      m_second = !m_second;
   endtask

   task automatic check_regs(input string req);
      chk({req, " div"}, div_o, e_div);
      chk({req, " ctl"}, {pump_o, test_o, tri_o, ud_o}, {e_pump, e_test, e_tri, e_ud});
      chk({req, " port"}, port_o, e_port);
   endtask

   // sends address and n data bytes (packed MSB-first in d), then stop
   task automatic telegram(input logic [7:0] ab, input logic [31:0] d, input int n,
                           input string req);
      logic ack, ok;
      ok = (ab == addr_of(asel));
      bus_start;
      send_byte(ab, ack);
      chk({req, " R2/R3 addr ack"}, ack, ok);
      m_second = 0;
      for (int i = 0; i < n; i++) begin
         send_byte(d[31-8*i -: 8], ack);
         chk({req, " R6 data ack"}, ack, ok);
         if (ok) model_byte(d[31-8*i -: 8]);
      end
      bus_stop;
      check_regs(req);
   endtask

   initial begin
      repeat (2000000 / 4) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      logic ack;
      void'($urandom(32'd20250611));
      repeat (5) @(negedge clk);
      chk("R1 pull in reset", sda_pull, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk("R1 pull after reset", sda_pull, 0);
      check_regs("R1");

      // R4 divider pair
      telegram(addr_of(asel), {8'h7F, 8'hFF, 16'h0}, 2, "R4");
      telegram(addr_of(asel), {8'h2A, 8'h5C, 16'h0}, 2, "R4");
      // R5 control pair
      telegram(addr_of(asel), {8'hF1, 8'h97, 16'h0}, 2, "R5");
      // R7 control first, then divider
      telegram(addr_of(asel), {8'h82, 8'h10, 8'h11, 8'h22}, 4, "R7");
      // R8 stop after first byte of a pair
      telegram(addr_of(asel), {8'h05, 24'h0}, 1, "R8");
      telegram(addr_of(asel), {8'h13, 8'h44, 8'hD0, 8'h0}, 3, "R8");
      // R3 wrong select and read bit
      telegram(addr_of(~asel), {8'h01, 8'h02, 16'h0}, 2, "R3");
      telegram(addr_of(asel) | 8'h01, {8'hFF, 8'hFF, 16'h0}, 2, "R3");

      // R9 repeated start after the first byte of a pair
      bus_start; send_byte(addr_of(asel), ack); chk("R9 addr", ack, 1);
      send_byte(8'h3C, ack); m_second = 0; model_byte(8'h3C);
      bus_start; send_byte(addr_of(asel), ack); chk("R9 re-addr ack", ack, 1);
      m_second = 0;
      send_byte(8'hA1, ack); model_byte(8'hA1);
      send_byte(8'h83, ack); model_byte(8'h83);
      chk("R9 data ack", ack, 1);
      bus_stop; check_regs("R9");

      // random telegrams
      for (int t = 0; t < 40; t++) begin
         logic [7:0] ab;
         logic [15:0] dr, cw;
         int n;
         asel = 2'($urandom);
         repeat (4) @(negedge clk);
         dr = {1'b0, 15'($urandom)};
         cw = {1'b1, 15'($urandom)};
         n = $urandom % 5;
         ab = addr_of(asel);
         if ($urandom % 5 == 0) ab = ab ^ (($urandom % 2) ? 8'h04 : 8'h01);
         if ($urandom % 2) telegram(ab, {dr, cw}, n, "R7 rnd");
         else telegram(ab, {cw, dr}, n, "R5 rnd");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule